// File: doc/BRIEF.md
# Loss-of-signal output selector

This block produces the loss-of-signal indication of an optical transceiver controller. It selects one of two sources. The first is an external comparator pin, which arrives asynchronously and is first passed through a two-stage synchronizer. The second is an internal quick-trip low-power flag, which is already synchronous to the block clock. The selected value is the receive-loss status bit. It can be inverted before it drives an open-drain style pull-down enable.

The select and invert settings are written into shadow bits at any time. They reach the active configuration only on a rising edge of the supply-valid input. While the supply is not valid, the block runs with the default configuration: pin source, no inversion. This keeps a half-recalled setting from steering the output during power-up.

Top module: `los_out_select`

## Requirements
- R1: While reset is high and after reset, the shadow and active configurations are both the default: pin source and no inversion. The synchronizer stages reset to 0, so rx_loss_o is 0 and pull_low_o is 1.
- R2: With the pin source active (source bit = 1), rx_loss_o equals the los_pin_i value sampled two rising clock edges earlier.
- R3: With the quick-trip source active (source bit = 0), rx_loss_o equals qt_low_i in the same cycle, with no register delay.
- R4: pull_low_o is 1 exactly when rx_loss_o XOR the active invert bit is 0.
- R5: After any clock edge at which supply_ok_i is sampled low, the active configuration is the default (pin source, no inversion), whatever the shadow holds.
- R6: A clock edge with cfg_wr_i high loads cfg_wdata_i into the shadow, with bit 0 as the source bit (1 = pin, 0 = quick trip) and bit 1 as the invert bit. While supply_ok_i stays high, a write does not change the active configuration.
- R7: At an edge where supply_ok_i is sampled high after having been sampled low at the previous edge, the active configuration takes the shadow value. If a write occurs at that same edge, it takes cfg_wdata_i instead.
- R8: When supply_ok_i falls, the edge that samples it low returns the outputs to default behaviour. The next rising edge of supply_ok_i applies the shadow again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| los_pin_i | input | 1 | External comparator loss indication, asynchronous |
| qt_low_i | input | 1 | Internal quick-trip low-power flag, synchronous |
| supply_ok_i | input | 1 | Supply above power-on threshold |
| cfg_wr_i | input | 1 | Write strobe for the shadow configuration |
| cfg_wdata_i | input | 2 | Bit 0 source (1 = pin), bit 1 invert |
| rx_loss_o | output | 1 | Selected loss indication (status bit) |
| pull_low_o | output | 1 | Open-drain pull-down enable (1 = pull low) |

## Verification
Random pin and quick-trip values that toggle every cycle separate the two-edge synchronizer latency of the pin path from the zero-latency quick-trip path. A wrong stage count or a wrong source therefore disagrees within a few cycles. Writes issued while the supply is steady high, while it is low, and on the very edge where it rises distinguish the three loading cases. Rare supply drops show that the default configuration returns whatever the shadow holds. Both invert settings are applied under each source, so a missing or doubled inversion on the pull-down enable is exposed.

// File: rtl/los_sel_pkg.sv
package los_sel_pkg;

    // Configuration word: bit 1 invert, bit 0 source (1 = pin)
    typedef struct packed {
        logic inv;
        logic src_pin;
    } los_cfg_t;

    localparam int CFG_W = $bits(los_cfg_t);

    localparam los_cfg_t CFG_DEFAULT = '{inv: 1'b0, src_pin: 1'b1};

    // Level driven toward the open-drain stage
    function automatic logic drive_level(input logic status, input logic inv);
        return status ^ inv;
    endfunction

    // Pull-down is enabled when the driven level is low
    function automatic logic pull_enable(input logic level);
        return ~level;
    endfunction

endpackage

// File: rtl/los_sync.sv
module los_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[LAST];
endmodule

// File: rtl/los_cfg_ctrl.sv
module los_cfg_ctrl
    import los_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     supply_ok_i,
    input  logic     wr_i,
    input  los_cfg_t wdata_i,
    output los_cfg_t shadow_o,
    output los_cfg_t active_o
);
    los_cfg_t shadow_q;
    los_cfg_t active_q;
    logic     supply_q;
    logic     supply_rise;
    los_cfg_t load_val;

    assign supply_rise = supply_ok_i & ~supply_q;
    assign load_val    = wr_i ? wdata_i : shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= CFG_DEFAULT;
            active_q <= CFG_DEFAULT;
            supply_q <= 1'b0;
        end else begin
            supply_q <= supply_ok_i;
            if (wr_i) begin
                shadow_q <= wdata_i;
            end
            if (!supply_ok_i) begin
                active_q <= CFG_DEFAULT;
            end else if (supply_rise) begin
                active_q <= load_val;
            end
        end
    end

    assign shadow_o = shadow_q;
    assign active_o = active_q;
endmodule

// File: rtl/los_drive.sv
module los_drive
    import los_sel_pkg::*;
(
    input  los_cfg_t cfg_i,
    input  logic     pin_sync_i,
    input  logic     qt_low_i,
    output logic     status_o,
    output logic     pull_low_o
);
    logic level;

    always_comb begin
        status_o   = cfg_i.src_pin ? pin_sync_i : qt_low_i;
        level      = drive_level(status_o, cfg_i.inv);
        pull_low_o = pull_enable(level);
    end
endmodule

// File: rtl/los_out_select.sv
module los_out_select
    import los_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       los_pin_i,
    input  logic       qt_low_i,
    input  logic       supply_ok_i,
    input  logic       cfg_wr_i,
    input  logic [1:0] cfg_wdata_i,
    output logic       rx_loss_o,
    output logic       pull_low_o
);
    los_cfg_t wdata;
    los_cfg_t shadow;
    los_cfg_t active;
    logic     pin_sync;

    assign wdata = los_cfg_t'(cfg_wdata_i);

    los_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (los_pin_i),
        .q_o (pin_sync)
    );

    los_cfg_ctrl u_cfg (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (supply_ok_i),
        .wr_i        (cfg_wr_i),
        .wdata_i     (wdata),
        .shadow_o    (shadow),
        .active_o    (active)
    );

    los_drive u_drive (
        .cfg_i      (active),
        .pin_sync_i (pin_sync),
        .qt_low_i   (qt_low_i),
        .status_o   (rx_loss_o),
        .pull_low_o (pull_low_o)
    );
endmodule

// File: rtl/los_out_select_chk.sv
module los_out_select_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       los_pin_i,
    input logic       supply_ok_i,
    input logic       cfg_wr_i,
    input logic [1:0] cfg_wdata_i,
    input logic [1:0] shadow,
    input logic [1:0] active,
    input logic       rx_loss_o,
    input logic       pull_low_o
);
    logic [SYNC_STAGES-1:0] pin_hist;
    int unsigned            since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_hist  <= '0;
            since_rst <= 0;
        end else begin
            pin_hist <= {pin_hist[SYNC_STAGES-2:0], los_pin_i};
            if (since_rst < 1000) since_rst <= since_rst + 1;
        end
    end

    // R5: after an edge with supply low, no inversion on the pull-down
    assert_default_noinv_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 1 && !$past(supply_ok_i)) |-> (pull_low_o == !rx_loss_o));

    // R5: after an edge with supply low, status follows the delayed pin
    assert_default_pin_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= SYNC_STAGES && !$past(supply_ok_i))
            |-> (rx_loss_o == pin_hist[SYNC_STAGES-1]));

    // R6: with supply held high, the active configuration does not move
    assert_hold_active_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 1 && $past(supply_ok_i) && supply_ok_i) |=> $stable(active));

    // R7: a supply rise applies the shadow or a same-edge write
    assert_rise_load_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 1 && $rose(supply_ok_i))
            |=> (active == ($past(cfg_wr_i) ? $past(cfg_wdata_i) : $past(shadow))));
endmodule

bind los_out_select los_out_select_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .los_pin_i   (los_pin_i),
    .supply_ok_i (supply_ok_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .shadow      (shadow),
    .active      (active),
    .rx_loss_o   (rx_loss_o),
    .pull_low_o  (pull_low_o)
);

// File: tb/los_out_select_bench.sv
module los_out_select_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       los_pin_i, qt_low_i, supply_ok_i, cfg_wr_i;
    logic [1:0] cfg_wdata_i;
    logic       rx_loss_o, pull_low_o;

    int checks = 0;
    int fails  = 0;

    // bench model state
    logic       m_p1, m_p2, m_supq;
    logic [1:0] m_sh, m_act;

    always #(CLK_PERIOD/2) clk = ~clk;

    los_out_select u_los_out_select (
        .clk(clk), .rst(rst), .los_pin_i(los_pin_i), .qt_low_i(qt_low_i),
        .supply_ok_i(supply_ok_i), .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i),
        .rx_loss_o(rx_loss_o), .pull_low_o(pull_low_o)
    );

    function automatic logic exp_status(logic [1:0] act, logic p2, logic qt);
        return act[0] ? p2 : qt;
    endfunction

    function automatic logic exp_pull(logic st, logic [1:0] act);
        return !(st ^ act[1]);
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_p1 = 0; m_p2 = 0; m_sh = 2'b01; m_act = 2'b01; m_supq = 0;
        end else begin
            m_p2 = m_p1;
            m_p1 = los_pin_i;
            if (!supply_ok_i) m_act = 2'b01;
            else if (!m_supq) m_act = cfg_wr_i ? cfg_wdata_i : m_sh;
            if (cfg_wr_i) m_sh = cfg_wdata_i;
            m_supq = supply_ok_i;
        end
    endtask

    task automatic check(string tag);
        logic  es, ep;
        string t;
        es = exp_status(m_act, m_p2, qt_low_i);
        ep = exp_pull(es, m_act);
        if (tag != "") t = tag;
        else if (!m_supq) t = "R5";
        else if (m_act[0]) t = "R2";
        else t = "R3";
        checks++;
        if (rx_loss_o !== es) begin
            fails++;
            $display("FAIL %s rx_loss_o actual %b expected %b", t, rx_loss_o, es);
        end
        checks++;
        if (pull_low_o !== ep) begin
            fails++;
            $display("FAIL R4 pull_low_o actual %b expected %b", pull_low_o, ep);
        end
    endtask

    // one clock: inputs are already set; sample at the following negedge
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic drive(logic pin, logic qt, logic sup, logic wr, logic [1:0] wd);
        los_pin_i = pin; qt_low_i = qt; supply_ok_i = sup; cfg_wr_i = wr; cfg_wdata_i = wd;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1a2b3c4d;
        logic sup;
        rst = 1;
        drive(0, 0, 0, 0, 2'b00);
        step("R1");
        step("R1");
        rst = 0;
        drive(0, 1, 0, 0, 2'b00);
        step("R1");

        // latency on the pin path: one edge is not enough, two are
        drive(1, 0, 0, 0, 2'b00);
        step("R2");
        drive(1, 0, 0, 0, 2'b00);
        step("R2");
        step("R2");

        // shadow written while supply low: no effect (quick trip, invert)
        drive(0, 1, 0, 1, 2'b10);
        step("R5");
        drive(0, 1, 0, 0, 2'b00);
        step("R5");
        // rise applies shadow
        drive(1, 1, 1, 0, 2'b00);
        step("R7");
        drive(1, 0, 1, 0, 2'b00);
        step("R3");
        // write while supply steady: ignored until next rise
        drive(1, 1, 1, 1, 2'b01);
        step("R6");
        for (int i = 0; i < 6; i++) begin
            drive(i[0], i[1], 1, 0, 2'b00);
            step("R6");
        end
        // drop supply: default returns
        drive(0, 1, 0, 0, 2'b00);
        step("R8");
        step("R8");
        // rise with simultaneous write: write data wins
        drive(0, 1, 1, 1, 2'b10);
        step("R7");
        drive(1, 0, 1, 0, 2'b00);
        step("R7");

        // constrained random
        sup = 1;
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom(seed);
            seed = seed + 32'h9e3779b9;
            if (r[7:2] == 0) sup = ~sup;
            drive(r[8], r[9], sup, (r[13:10] == 0), r[15:14]);
            step("");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule